// File: doc/BRIEF.md
# UART Host Holding-Register Interface

This block is the register layer that a processor sees when it talks to a UART. The processor reaches it through a small memory-mapped port: an address, a write strobe, a read strobe and a data word. On the other side it faces a serializer core through plain handshake wires. It holds exactly one character on the way out and one character on the way in. There are no queues. Every bus access moves one character.

Two status bits support software polling. The transmit-empty bit says the outgoing slot can take another character. The data-ready bit says a received character is waiting. Reading the receive word through its normal address consumes the character and clears data-ready. A third bit, overrun, records a received character that replaced one nobody had read. Reading the status through its normal address clears overrun.

Two further alias addresses return the receive word and the status word with no side effects. A debugger can inspect the block through them without disturbing the software that is running. An optional ninth received bit can be carried in the receive word.

Top module: `uart_hold_regs`

## Requirements
- R1: After synchronous reset:
  - tx_valid is 0;
  - the status reads transmit-empty = 1, data-ready = 0 and overrun = 0;
  - the receive word reads 0.
- R2: A bus write to address 0 loads bus_wdata[7:0] into the transmit slot. On the next cycle tx_valid is 1, tx_data equals that byte, and status transmit-empty is 0.
- R3: A write to address 0 while the transmit slot is already full replaces the pending character. tx_data then shows only the newest byte, and the replaced byte is never presented.
- R4: A tx_load while the slot is full empties it on the next cycle, so tx_valid becomes 0 and transmit-empty becomes 1. If a write to address 0 falls in the same cycle as tx_load, the slot stays full and holds the new byte.
- R5: rx_valid stores {rx_bit9, rx_data} into the receive word and sets data-ready on the next cycle.
- R6: A read strobe at address 0 returns the receive word and clears data-ready on the next cycle. If rx_valid falls in the same cycle, data-ready stays 1 and the new character is kept.
- R7: Read strobes at address 2 (receive word alias) and address 3 (status alias) return the same values as addresses 0 and 1. They change no flag.
- R8: Overrun is set when rx_valid arrives while data-ready is already 1 and no address-0 read falls in the same cycle. In that case the receive word is overwritten. A read strobe at address 1 clears overrun on the next cycle, unless a new overrun occurs in that same cycle.
- R9: Receive word layout:
  - bits 7:0 hold the data;
  - bit 8 holds the ninth bit when NINE_BIT = 1 and reads 0 otherwise;
  - all higher bits read 0.
  
  Status layout: bit 0 is data-ready, bit 1 is overrun, bit 2 is transmit-empty, and every other bit reads 0.
- R10: Writes to any address other than 0 change nothing. Reads of addresses 4 and above return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; enables read side effects |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the addressed register (combinational) |
| tx_valid | output | 1 | Transmit slot holds a character |
| tx_data | output | DATA_W | Pending transmit character |
| tx_load | input | 1 | Serializer takes the pending character |
| rx_valid | input | 1 | Deserializer delivers a character |
| rx_data | input | DATA_W | Received data bits |
| rx_bit9 | input | 1 | Received ninth bit |

## Verification
Collisions come in three pairs, and each pair can hit the same clock edge:
- the serializer's tx_load against a processor write to the transmit slot;
- a character arrival against a consuming receive read;
- a character arrival against a status read that would clear overrun.

Directed steps force each of these collisions on purpose. Biased random traffic then makes them recur many times, with address, strobes, load and arrival drawn independently every cycle. After each edge a bench model built from the requirements predicts:
- the next transmit state;
- data-ready;
- overrun;
- the receive word.

Each prediction is compared with the read data and the transmit outputs before the following edge.

// File: rtl/uart_hold_pkg.sv
package uart_hold_pkg;
   // register addresses (low address bits)
   localparam int ADDR_DATA    = 0;
   localparam int ADDR_STAT    = 1;
   localparam int ADDR_SH_DATA = 2;
   localparam int ADDR_SH_STAT = 3;

   // status bit positions
   localparam int ST_READY   = 0;
   localparam int ST_OVERRUN = 1;
   localparam int ST_TXEMPTY = 2;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_STAT,
      SEL_SH_DATA,
      SEL_SH_STAT
   } rd_sel_t;

   typedef struct packed {
      logic tx_empty;
      logic overrun;
      logic ready;
   } stat_t;
endpackage

// File: rtl/uart_hold_decode.sv
module uart_hold_decode
   import uart_hold_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_thr,
   output logic              rd_consume,
   output logic              rd_stat_clr,
   output rd_sel_t           sel
);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADDR_DATA);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
   localparam logic [ADDR_W-1:0] A_SHD  = ADDR_W'(ADDR_SH_DATA);
   localparam logic [ADDR_W-1:0] A_SHS  = ADDR_W'(ADDR_SH_STAT);

   always_comb begin
      if (addr == A_DATA)      sel = SEL_DATA;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_SHD)  sel = SEL_SH_DATA;
      else if (addr == A_SHS)  sel = SEL_SH_STAT;
      else                     sel = SEL_NONE;
   end

   assign wr_thr      = wr && (sel == SEL_DATA);
   assign rd_consume  = rd && (sel == SEL_DATA);
   assign rd_stat_clr = rd && (sel == SEL_STAT);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_thr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tx_load,
   output logic              full,
   output logic [DATA_W-1:0] hold
);
   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         hold <= '0;
      end else if (wr_thr) begin
         // a new write wins over a same-cycle load and over a pending character
         full <= 1'b1;
         hold <= wdata;
      end else if (tx_load) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int DATA_W   = 8,
   parameter bit NINE_BIT = 1'b1,
   localparam int WORD_W  = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_bit9,
   input  logic              rd_consume,
   input  logic              rd_stat_clr,
   output logic [WORD_W-1:0] word,
   output logic              ready,
   output logic              overrun
);
   logic [DATA_W-1:0] data_q;
   logic              top_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q  <= '0;
         ready   <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (rx_valid) begin
            data_q <= rx_data;
            ready  <= 1'b1;
         end else if (rd_consume) begin
            ready  <= 1'b0;
         end
         if (rx_valid && ready && !rd_consume) overrun <= 1'b1;
         else if (rd_stat_clr)                 overrun <= 1'b0;
      end
   end

   generate
      if (NINE_BIT) begin : g_nine
         logic bit9_q;
         always_ff @(posedge clk) begin
            if (rst)           bit9_q <= 1'b0;
            else if (rx_valid) bit9_q <= rx_bit9;
         end
         assign top_bit = bit9_q;
      end else begin : g_eight
         logic unused_bit9;
         assign unused_bit9 = rx_bit9;
         assign top_bit     = 1'b0;
      end
   endgenerate

   assign word = {top_bit, data_q};
endmodule

// File: rtl/uart_hold_rdmux.sv
module uart_hold_rdmux
   import uart_hold_pkg::*;
#(
   parameter int BUS_W  = 32,
   parameter int WORD_W = 9
) (
   input  rd_sel_t           sel,
   input  logic [WORD_W-1:0] rx_word,
   input  stat_t             stat,
   output logic [BUS_W-1:0]  rdata
);
   always_comb begin
      rdata = '0;
      case (sel)
         SEL_DATA, SEL_SH_DATA: rdata[WORD_W-1:0] = rx_word;
         SEL_STAT, SEL_SH_STAT: begin
            rdata[ST_READY]   = stat.ready;
            rdata[ST_OVERRUN] = stat.overrun;
            rdata[ST_TXEMPTY] = stat.tx_empty;
         end
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/uart_hold_regs.sv
module uart_hold_regs
   import uart_hold_pkg::*;
#(
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter bit NINE_BIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_bit9
);
   localparam int WORD_W = DATA_W + 1;

   generate
      if (BUS_W < WORD_W || BUS_W < ST_TXEMPTY + 1) begin : g_bad_bus
         $error("uart_hold_regs: BUS_W too narrow");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("uart_hold_regs: ADDR_W must cover four registers");
      end
   endgenerate

   logic              wr_thr, rd_consume, rd_stat_clr;
   rd_sel_t           sel;
   logic              tx_full;
   logic              rx_ready, rx_overrun;
   logic [WORD_W-1:0] rx_word;
   stat_t             stat;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[BUS_W-1:DATA_W];

   uart_hold_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wr_thr(wr_thr), .rd_consume(rd_consume),
      .rd_stat_clr(rd_stat_clr), .sel(sel)
   );

   uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst(rst), .wr_thr(wr_thr),
      .wdata(bus_wdata[DATA_W-1:0]), .tx_load(tx_load),
      .full(tx_full), .hold(tx_data)
   );

   uart_rx_hold #(.DATA_W(DATA_W), .NINE_BIT(NINE_BIT)) u_rx (
      .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rd_consume(rd_consume),
      .rd_stat_clr(rd_stat_clr), .word(rx_word),
      .ready(rx_ready), .overrun(rx_overrun)
   );

   assign stat.ready    = rx_ready;
   assign stat.overrun  = rx_overrun;
   assign stat.tx_empty = !tx_full;

   uart_hold_rdmux #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_mux (
      .sel(sel), .rx_word(rx_word), .stat(stat), .rdata(bus_rdata)
   );

   assign tx_valid = tx_full;
endmodule

// File: rtl/uart_hold_chk.sv
module uart_hold_chk #(
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 8,
   parameter bit NINE_BIT = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_data,
   input logic              tx_load,
   input logic              rx_valid,
   input logic              ready,
   input logic              overrun
);
   localparam logic [ADDR_W-1:0] A0 = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A1 = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A2 = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A3 = ADDR_W'(3);
   localparam int TOP = NINE_BIT ? DATA_W + 1 : DATA_W;

   logic after_rst = 1'b0;
   always_ff @(posedge clk) after_rst <= rst;

   // R1
   always @(posedge clk) begin
      if (after_rst && !rst)
         reset_state_chk: assert (!tx_valid && !ready && !overrun);
   end

   // R9
   always @(posedge clk) begin
      if (!rst && (bus_addr == A2))
         upper_zero_chk: assert (bus_rdata[BUS_W-1:TOP] == '0);
   end

   // R2
   thr_fill_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A0) |=> (tx_valid && tx_data == $past(bus_wdata[DATA_W-1:0])));

   // R4
   load_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_load && tx_valid && !(bus_wr && bus_addr == A0)) |=> !tx_valid);

   // R5
   rx_ready_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> ready);

   // R6
   consume_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == A0 && !rx_valid) |=> !ready);

   // R7
   shadow_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && (bus_addr == A2 || bus_addr == A3) && !rx_valid && !bus_wr && !tx_load)
      |=> ($stable(ready) && $stable(overrun) && $stable(tx_valid)));

   // R8
   overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && ready && !(bus_rd && bus_addr == A0)) |=> overrun);

   // R8
   overrun_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == A1 && !(rx_valid && ready)) |=> !overrun);
endmodule

bind uart_hold_regs uart_hold_chk #(
   .BUS_W(BUS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NINE_BIT(NINE_BIT)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .tx_valid(tx_valid), .tx_data(tx_data), .tx_load(tx_load),
   .rx_valid(rx_valid), .ready(rx_ready), .overrun(rx_overrun)
);

// File: tb/uart_hold_regs_tb.sv
module uart_hold_regs_tb;
   localparam int BUS_W = 32;
   localparam int ADDR_W = 3;
   localparam int DATA_W = 8;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_wr = 1'b0, bus_rd = 1'b0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic              tx_valid;
   logic [DATA_W-1:0] tx_data;
   logic              tx_load = 1'b0, rx_valid = 1'b0, rx_bit9 = 1'b0;
   logic [DATA_W-1:0] rx_data = '0;

   int n_chk = 0, n_err = 0;

   // model state
   logic       m_full = 1'b0, m_rdy = 1'b0, m_ovr = 1'b0;
   logic [7:0] m_txd = '0;
   logic [8:0] m_rbr = '0;

   always #2 clk = ~clk;

   uart_hold_regs u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_load(tx_load),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9)
   );

   function automatic logic [BUS_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
      case (a)
         3'd0, 3'd2: return {23'd0, m_rbr};
         3'd1, 3'd3: return {29'd0, !m_full, m_ovr, m_rdy};
         default:    return '0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus cycle: drive, check the state left by the previous cycle, clock, update model
   task automatic step(input string tag, input logic [ADDR_W-1:0] a, input logic w, input logic r,
                       input logic [7:0] wd, input logic ld, input logic rv,
                       input logic [7:0] rd, input logic b9);
      string t;
      logic  wthr, rcons, rstat;
      logic  n_ovr;
      @(negedge clk);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = {$urandom, wd} >> 0;
      bus_wdata[7:0] = wd;
      tx_load = ld; rx_valid = rv; rx_data = rd; rx_bit9 = b9;
      #1;
      if (tag != "") t = tag;
      else if (a == 0) t = "R6";
      else if (a == 1) t = "R9";
      else if (a < 4) t = "R7";
      else t = "R10";
      chk({t, " rdata"}, bus_rdata, exp_rd(a));
      chk({tag == "" ? "R2" : tag, " tx_valid"}, {31'd0, tx_valid}, {31'd0, m_full});
      if (m_full) chk({tag == "" ? "R3" : tag, " tx_data"}, {24'd0, tx_data}, {24'd0, m_txd});
      @(posedge clk);
      wthr  = w && a == 0;
      rcons = r && a == 0;
      rstat = r && a == 1;
      if (wthr) begin m_full = 1'b1; m_txd = wd; end
      else if (ld) m_full = 1'b0;
      n_ovr = (rv && m_rdy && !rcons) ? 1'b1 : (rstat ? 1'b0 : m_ovr);
      if (rv) begin m_rbr = {b9, rd}; m_rdy = 1'b1; end
      else if (rcons) m_rdy = 1'b0;
      m_ovr = n_ovr;
   endtask

   initial begin
      #800000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      // R1: reset state, status then receive word
      step("R1", 3'd1, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      step("R1", 3'd0, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R2: write fills the transmit slot
      step("R2", 3'd0, 1, 0, 8'hA5, 0, 0, 8'h00, 0);
      step("R2", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R3: overwrite pending character
      step("R3", 3'd0, 1, 0, 8'h3C, 0, 0, 8'h00, 0);
      step("R3", 3'd1, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R4: load and write together, then load alone
      step("R4", 3'd0, 1, 0, 8'h77, 1, 0, 8'h00, 0);
      step("R4", 3'd3, 0, 0, 8'h00, 1, 0, 8'h00, 0);
      step("R4", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R10: write elsewhere has no effect
      step("R10", 3'd1, 1, 0, 8'hFF, 0, 0, 8'h00, 0);
      step("R10", 3'd2, 1, 0, 8'hEE, 0, 0, 8'h00, 0);
      step("R10", 3'd5, 0, 1, 8'h00, 0, 0, 8'h00, 0);
      // R5: receive with ninth bit
      step("R5", 3'd3, 0, 0, 8'h00, 0, 1, 8'h5A, 1);
      step("R5", 3'd2, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R7: shadow reads leave flags alone
      step("R7", 3'd2, 0, 1, 8'h00, 0, 0, 8'h00, 0);
      step("R7", 3'd3, 0, 1, 8'h00, 0, 0, 8'h00, 0);
      step("R7", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R8: overrun, then cleared by status read
      step("R8", 3'd3, 0, 0, 8'h00, 0, 1, 8'h11, 0);
      step("R8", 3'd1, 0, 1, 8'h00, 0, 0, 8'h00, 0);
      step("R8", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R6: consuming read with arrival in same cycle, then alone
      step("R6", 3'd0, 0, 1, 8'h00, 0, 1, 8'h22, 1);
      step("R6", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      step("R6", 3'd0, 0, 1, 8'h00, 0, 0, 8'h00, 0);
      step("R6", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // R9: ninth bit zero, full data byte
      step("R9", 3'd0, 0, 0, 8'h00, 0, 1, 8'hFF, 0);
      step("R9", 3'd0, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         step("", 3'($urandom % 8), ($urandom % 4) == 0, ($urandom % 3) == 0,
              8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
              8'($urandom), 1'($urandom));
      end
      step("", 3'd3, 0, 0, 8'h00, 0, 0, 8'h00, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule